// File: doc/BRIEF.md
# ADC Channel Scan Timing Sequencer

This block sequences a multi-channel successive-approximation converter through a range of analog inputs. A 16-bit setting register holds a sampling-time code, a comparison-time code, a first channel and a last channel. A start pulse begins a scan at the first channel. For each channel the block raises a sample strobe and then a compare strobe, each for a fixed number of machine-clock cycles chosen by its code. It then gives a one-cycle channel-done pulse and moves to the next channel. It steps upward through the channels and wraps from 15 to 0 when the first channel is above the last.

While a scan is active the first-channel field of the register reads back the live channel number, and a shadow copy keeps the programmed value. In pause mode the block halts after each channel-done pulse and holds the channel number it has just finished. A further start pulse resumes it at the next channel. Register writes made while the block is busy are discarded.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `rd_data` is 0x0000, `sample`, `compare`, `ch_done` and `busy` are low, and `ch_sel` is 0.
- R2: In idle, a write stores the register, and reads return it with bits 9 and 4 forced to 0. The fields are: sampling code in bits 15:13, comparison code in bits 12:10, first channel in bits 8:5, last channel in bits 3:0.
- R3: For each channel, `sample` is high for exactly 4, 6, 8, 12, 24, 36, 48 or 128 consecutive cycles for sampling codes 0 to 7.
- R4: `compare` follows `sample` directly and is high for exactly 22, 33, 44, 66, 88, 132, 176 or 264 cycles for comparison codes 0 to 7.
- R5: `ch_sel` visits the channels from the first channel upward to the last channel, one per channel period. When the first channel is greater than the last, the count wraps from 15 to 0.
- R6: `ch_done` is high for one cycle right after the last compare cycle of each channel. Outside pause mode, the next channel's sample phase starts in the cycle after that.
- R7: While busy, bits 8:5 of `rd_data` return the current `ch_sel` value, and the other fields keep their programmed values.
- R8: Writes while busy are ignored. After the scan, reads return the register as last written in idle, including the programmed first channel.
- R9: With `pause_mode` high, the block stops after each non-final `ch_done`: `busy` stays high, the strobes stay low, and bits 8:5 read the channel just converted. A `start` pulse resumes the scan at the next channel.
- R10: A `start` pulse during a sample or compare phase has no effect on the sequence.
- R11: In the cycle after `ch_done` for the last channel, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| start | input | 1 | Start pulse, or resume pulse when paused |
| pause_mode | input | 1 | Halt after each channel |
| ch_sel | output | 4 | Channel select to the analog multiplexer |
| sample | output | 1 | Sample phase strobe |
| compare | output | 1 | Compare phase strobe |
| ch_done | output | 1 | One-cycle end-of-channel pulse |
| busy | output | 1 | Scan active, including while paused |

## Verification
Directed scans use a single channel, the full 0 to 15 range, and a wrapping range from 14 to 1. Together they separate correct stepping from an off-by-one end test and from missing wrap logic. Random scans draw both timing codes, both channel fields and pause mode, so every length in both tables is set against the bench's own table. Writes and start pulses injected during a sample phase show whether the busy gating holds. Readback sampled in every phase tells the live channel number apart from the shadowed programmed value.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W  = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic             start,
  input  logic             pause_mode,
  output logic [CH_W-1:0]  ch_sel,
  output logic             sample,
  output logic             compare,
  output logic             ch_done,
  output logic             busy
);

  typedef enum logic [2:0] {S_IDLE, S_SAMP, S_CMP, S_DONE, S_HOLD} state_t;

  state_t            state;
  logic [2:0]        st_code, ct_code;
  logic [CH_W-1:0]   first_ch, last_ch, ch;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] samp_len(input logic [2:0] c);
    case (c)
      3'd0: samp_len = CNT_W'(4);
      3'd1: samp_len = CNT_W'(6);
      3'd2: samp_len = CNT_W'(8);
      3'd3: samp_len = CNT_W'(12);
      3'd4: samp_len = CNT_W'(24);
      3'd5: samp_len = CNT_W'(36);
      3'd6: samp_len = CNT_W'(48);
      default: samp_len = CNT_W'(128);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cmp_len(input logic [2:0] c);
    case (c)
      3'd0: cmp_len = CNT_W'(22);
      3'd1: cmp_len = CNT_W'(33);
      3'd2: cmp_len = CNT_W'(44);
      3'd3: cmp_len = CNT_W'(66);
      3'd4: cmp_len = CNT_W'(88);
      3'd5: cmp_len = CNT_W'(132);
      3'd6: cmp_len = CNT_W'(176);
      default: cmp_len = CNT_W'(264);
    endcase
  endfunction

  assign busy    = (state != S_IDLE);
  assign sample  = (state == S_SAMP);
  assign compare = (state == S_CMP);
  assign ch_done = (state == S_DONE);
  assign ch_sel  = ch;
  assign rd_data = {st_code, ct_code, 1'b0, (busy ? ch : first_ch), 1'b0, last_ch};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_code  <= '0;
      ct_code  <= '0;
      first_ch <= '0;
      last_ch  <= '0;
    end else if (wr_en && !busy) begin
      st_code  <= wr_data[15:13];
      ct_code  <= wr_data[12:10];
      first_ch <= wr_data[8:5];
      last_ch  <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ch    <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_SAMP;
          ch    <= first_ch;
          cnt   <= samp_len(st_code) - 1'b1;
        end
        S_SAMP: if (cnt == '0) begin
          state <= S_CMP;
          cnt   <= cmp_len(ct_code) - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_CMP: if (cnt == '0) state <= S_DONE;
               else cnt <= cnt - 1'b1;
        S_DONE: if (ch == last_ch) state <= S_IDLE;
          else if (pause_mode) state <= S_HOLD;
          else begin
            state <= S_SAMP;
            ch    <= ch + 1'b1;
            cnt   <= samp_len(st_code) - 1'b1;
          end
        S_HOLD: if (start) begin
          state <= S_SAMP;
          ch    <= ch + 1'b1;
          cnt   <= samp_len(st_code) - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample, compare, ch_done}));

  assert_done_after_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_done) |-> $past(compare));

  assert_compare_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(compare) |-> $past(sample));

  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(st_code) && $stable(ct_code) && $stable(first_ch) && $stable(last_ch)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] == 1'b0) && (rd_data[4] == 1'b0));

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done && ch_sel == last_ch) |=> !busy);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sample && !compare && !ch_done) |-> (rd_data[8:5] == ch_sel));

  assert_live_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[8:5] == ch_sel));

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        start = 1'b0;
  logic        pause_mode = 1'b0;
  logic [3:0]  ch_sel;
  logic        sample, compare, ch_done, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .start(start), .pause_mode(pause_mode), .ch_sel(ch_sel), .sample(sample),
    .compare(compare), .ch_done(ch_done), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_samp(input int c);
    int t[8] = '{4, 6, 8, 12, 24, 36, 48, 128};
    return t[c];
  endfunction

  function automatic int exp_cmp(input int c);
    int t[8] = '{22, 33, 44, 66, 88, 132, 176, 264};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    wr_data = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_scan(input int st, input int ct, input int fc, input int lc, input bit pm);
    logic [15:0] prog;
    logic [15:0] keep;
    int c;
    int n;
    bit last;
    prog = {3'(st), 3'(ct), 1'b1, 4'(fc), 1'b1, 4'(lc)};
    keep = prog & 16'hFDEF;
    write_reg(prog);
    check(rd_data == keep, "R2", rd_data, keep);
    pause_mode = pm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = fc;
    last = 1'b0;
    while (!last) begin
      n = 0;
      while (sample && n < 300) begin
        if (ch_sel != 4'(c)) check(0, "R5", ch_sel, c);
        if (rd_data[8:5] != 4'(c)) check(0, "R7", rd_data[8:5], c);
        if (n == 1) begin
          wr_en = 1'b1;
          wr_data = 16'($urandom());
          start = 1'b1;
        end else begin
          wr_en = 1'b0;
          start = 1'b0;
        end
        n++;
        @(negedge clk);
      end
      wr_en = 1'b0;
      start = 1'b0;
      check(n == exp_samp(st), "R3", n, exp_samp(st));
      n = 0;
      while (compare && n < 300) begin
        if (ch_sel != 4'(c)) check(0, "R5", ch_sel, c);
        n++;
        @(negedge clk);
      end
      check(n == exp_cmp(ct), "R4", n, exp_cmp(ct));
      check(ch_done == 1'b1, "R6", ch_done, 1);
      check(ch_sel == 4'(c), "R5", ch_sel, c);
      check(rd_data[15:9] == keep[15:9] && rd_data[3:0] == keep[3:0], "R7", rd_data, keep);
      last = (c == lc);
      @(negedge clk);
      if (last) begin
        check(busy == 1'b0 && !sample, "R11", busy, 0);
        check(rd_data == keep, "R8", rd_data, keep);
      end else if (pm) begin
        repeat (3) @(negedge clk);
        check(busy && !sample && !compare && !ch_done, "R9", {busy, sample, compare, ch_done}, 4'b1000);
        check(rd_data[8:5] == 4'(c), "R9", rd_data[8:5], c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sample == 1'b1 && ch_sel == 4'((c + 1) % 16), "R9", ch_sel, (c + 1) % 16);
      end else begin
        check(sample == 1'b1, "R6", sample, 1);
      end
      c = (c + 1) % 16;
    end
    pause_mode = 1'b0;
  endtask

  initial begin
    int s;
    s = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    check(rd_data == 16'h0000, "R1", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0000 && !sample && !compare && !ch_done && !busy && ch_sel == 4'd0,
          "R1", rd_data, 0);
    write_reg(16'hFFFF);
    check(rd_data == 16'hFDEF, "R2", rd_data, 16'hFDEF);
    @(negedge clk);
    check(!busy && !sample, "R10", busy, 0);
    run_scan(0, 0, 5, 5, 0);
    run_scan(7, 7, 3, 3, 0);
    run_scan(0, 1, 0, 15, 0);
    run_scan(2, 3, 14, 1, 0);
    run_scan(1, 0, 13, 2, 1);
    for (int i = 0; i < 8; i++) run_scan(i, 7 - i, i, (i + 2) % 16, 0);
    for (int k = 0; k < 10; k++)
      run_scan($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 15),
               $urandom_range(0, 15), 1'($urandom_range(0, 1)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1990000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule